// File: doc/BRIEF.md
# Instruction Operand Fetch Sequencer

This block gathers the operands of a microcoded instruction. It takes a packed operand-pattern word and walks it one four-bit field at a time, starting from the least significant field. Each field code names one operand kind:

- a value taken from the A and B working registers;
- a constant placed in the word after the instruction;
- the address of such an inline word;
- an inline pointer that is resolved, through any number of indirect hops, either to an address or to a constant of one to five words.

Every operand word the block produces leaves on a registered write port, tagged with its operand slot and its word index. The surrounding microcode engine can therefore fill its own operand buffer. Memory reads go through a valid/ready request channel with a separate response strobe, and only one read is outstanding at a time.

A start strobe captures the pattern, A, B and the program counter. The block then advances its own copy of the program counter past every inline word it consumes. It ends with a one-cycle done pulse. If an interrupt is pending while a pointer chain runs too deep, it ends instead with a one-cycle abort pulse. After an abort the instruction is expected to be retried once the interrupt has been serviced.

Top module: `operand_fetch_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, done, abort, op_wr_en and mem_req_valid are low and pc_out is zero.
- R2: Fields are taken from pattern bits [3:0] upward, one per operand. The operand from field position f is written with op_wr_slot = f. After all four fields have been handled, done pulses for one cycle.
- R3: Code 0 and the reserved codes 13, 14 and 15 end the walk at once: done pulses for one cycle, and no further read or write occurs.
- R4: Codes 1, 2 and 3 issue no memory read. Code 1 writes A as word 0. Codes 2 and 3 write A as word 0 and then B as word 1.
- R5: Code 4 reads the word at the program counter and writes it as word 0. Code 5 issues no read and writes the program counter, zero-extended, as word 0. After each operand with a code from 4 to 12, the program counter advances by one. It is 15 bits wide and wraps from 0x7FFF to 0x0000.
- R6: Codes 6 to 12 read a pointer word at the program counter. While a pointer word has bit 15 set, the next word is read from its bits [14:0]. The first word with bit 15 clear gives the resolved address from its bits [14:0]. Code 6 writes that address as word 0.
- R7: Codes 7, 8, 9, 10, 11 and 12 read 1, 2, 2, 3, 4 and 5 words respectively. The words come from the resolved address and the addresses that follow it, with a 15-bit wrap, and are written as words 0 upward in read order. For code 8 this puts the high half first.
- R8: If a fourth word with bit 15 set is reached for one operand while irq_pending is high, abort pulses instead of done and no further read or write follows. pc_out then excludes that operand's inline word. With irq_pending low, a chain of any depth is followed.
- R9: At most one read is outstanding at a time. mem_req_addr holds steady while mem_req_valid is high and mem_req_ready is low.
- R10: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk; sampled only when idle |
| pattern | input | 16 | Four packed 4-bit operand codes |
| reg_a | input | 16 | A register value |
| reg_b | input | 16 | B register value |
| pc_in | input | 15 | Address of the first inline word |
| irq_pending | input | 1 | Interrupt pending; enables the deep-chain abort |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | 15 | Read address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid, one cycle per request |
| mem_rsp_data | input | 16 | Read data |
| op_wr_en | output | 1 | Operand word write strobe |
| op_wr_slot | output | 2 | Operand slot (field position) |
| op_wr_word | output | 3 | Word index within the operand |
| op_wr_data | output | 16 | Operand word |
| pc_out | output | 15 | Program counter advanced past consumed inline words |
| done | output | 1 | One-cycle pulse at normal completion |
| abort | output | 1 | One-cycle pulse when the walk is abandoned for retry |

## Verification
The bench builds the block with its default parameters: 16-bit words, four fields and an indirection limit of three. Full-width words make bit 15 the indirect flag and put the 15-bit wrap at 0x7FFF within reach. Four fields let a pattern run out without a terminating code. The limit of three means a short four-hop chain reaches the abort, while a three-hop chain must still complete with the interrupt pending. Randomised ready stalls and response latencies of one to three cycles exercise the single-outstanding request channel under stalls.

// File: rtl/opf_pkg.sv
package opf_pkg;

  localparam int CODE_W    = 4;
  localparam int MAX_WORDS = 5;
  localparam int WORD_W    = $clog2(MAX_WORDS);

  typedef enum logic [CODE_W-1:0] {
    K_END      = 4'd0,
    K_REG_A    = 4'd1,
    K_REG_DINT = 4'd2,
    K_REG_FP   = 4'd3,
    K_INL_CON  = 4'd4,
    K_INL_VAR  = 4'd5,
    K_PTR_ADR  = 4'd6,
    K_PTR_W1   = 4'd7,
    K_PTR_DINT = 4'd8,
    K_PTR_F2   = 4'd9,
    K_PTR_F3   = 4'd10,
    K_PTR_F4   = 4'd11,
    K_PTR_F5   = 4'd12
  } opf_code_e;

  typedef struct packed {
    logic              ends;
    logic              from_regs;
    logic              is_inline;
    logic              reads_inline_value;
    logic              gives_addr;
    logic              gives_pc;
    logic [WORD_W-1:0] n_words;
  } opf_dec_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DISP,
    S_REG,
    S_WINL,
    S_WPTR,
    S_WDAT,
    S_NEXT
  } opf_state_e;

endpackage

// File: rtl/opf_decode.sv
module opf_decode
  import opf_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output opf_dec_t          dec
);

  always_comb begin
    dec = '0;
    case (code)
      K_REG_A: begin
        dec.from_regs = 1'b1;
        dec.n_words   = WORD_W'(1);
      end
      K_REG_DINT, K_REG_FP: begin
        dec.from_regs = 1'b1;
        dec.n_words   = WORD_W'(2);
      end
      K_INL_CON: begin
        dec.is_inline          = 1'b1;
        dec.reads_inline_value = 1'b1;
        dec.n_words            = WORD_W'(1);
      end
      K_INL_VAR: begin
        dec.is_inline = 1'b1;
        dec.gives_pc  = 1'b1;
        dec.n_words   = WORD_W'(1);
      end
      K_PTR_ADR: begin
        dec.is_inline  = 1'b1;
        dec.gives_addr = 1'b1;
        dec.n_words    = WORD_W'(1);
      end
      K_PTR_W1: begin
        dec.is_inline = 1'b1;
        dec.n_words   = WORD_W'(1);
      end
      K_PTR_DINT, K_PTR_F2: begin
        dec.is_inline = 1'b1;
        dec.n_words   = WORD_W'(2);
      end
      K_PTR_F3: begin
        dec.is_inline = 1'b1;
        dec.n_words   = WORD_W'(3);
      end
      K_PTR_F4: begin
        dec.is_inline = 1'b1;
        dec.n_words   = WORD_W'(4);
      end
      K_PTR_F5: begin
        dec.is_inline = 1'b1;
        dec.n_words   = WORD_W'(5);
      end
      default: dec.ends = 1'b1;
    endcase
  end

endmodule

// File: rtl/opf_mem_if.sv
module opf_mem_if #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr
);

  logic outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      outstanding_q <= 1'b0;
    end else begin
      if (issue) begin
        mem_req_valid <= 1'b1;
        mem_req_addr  <= issue_addr;
      end else if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
      end
      if (mem_req_valid && mem_req_ready)
        outstanding_q <= 1'b1;
      else if (mem_rsp_valid)
        outstanding_q <= 1'b0;
    end
  end

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> (!mem_req_valid && (!outstanding_q || mem_rsp_valid)));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: rtl/operand_fetch_seq.sv
module operand_fetch_seq
  import opf_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int N_FIELDS  = 4,
  parameter int IND_LIMIT = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [N_FIELDS*CODE_W-1:0]   pattern,
  input  logic [DATA_W-1:0]            reg_a,
  input  logic [DATA_W-1:0]            reg_b,
  input  logic [DATA_W-2:0]            pc_in,
  input  logic                         irq_pending,
  output logic                         mem_req_valid,
  output logic [DATA_W-2:0]            mem_req_addr,
  input  logic                         mem_req_ready,
  input  logic                         mem_rsp_valid,
  input  logic [DATA_W-1:0]            mem_rsp_data,
  output logic                         op_wr_en,
  output logic [$clog2(N_FIELDS)-1:0]  op_wr_slot,
  output logic [WORD_W-1:0]            op_wr_word,
  output logic [DATA_W-1:0]            op_wr_data,
  output logic [DATA_W-2:0]            pc_out,
  output logic                         done,
  output logic                         abort
);

  localparam int ADDR_W = DATA_W - 1;
  localparam int PAT_W  = N_FIELDS * CODE_W;
  localparam int SLOT_W = $clog2(N_FIELDS);
  localparam int FIDX_W = $clog2(N_FIELDS + 1);
  localparam int LVL_W  = $clog2(IND_LIMIT + 1);

  opf_state_e        state_q;
  logic [PAT_W-1:0]  pat_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [ADDR_W-1:0] pc_q, ma_q;
  logic [FIDX_W-1:0] fidx_q;
  logic [WORD_W-1:0] wcnt_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              issue_q;
  logic [ADDR_W-1:0] issue_addr_q;
  opf_dec_t          dec;

  opf_decode u_dec (
    .code (pat_q[CODE_W-1:0]),
    .dec  (dec)
  );

  opf_mem_if #(.ADDR_W(ADDR_W)) u_mem (
    .clk           (clk),
    .rst           (rst),
    .issue         (issue_q),
    .issue_addr    (issue_addr_q),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr)
  );

  logic              fields_spent, last_word, rsp_ind, too_deep;
  logic [ADDR_W-1:0] rsp_addr;
  logic [SLOT_W-1:0] slot;

  assign fields_spent = (fidx_q == FIDX_W'(N_FIELDS));
  assign last_word    = (wcnt_q == dec.n_words - WORD_W'(1));
  assign rsp_ind      = mem_rsp_data[DATA_W-1];
  assign rsp_addr     = mem_rsp_data[ADDR_W-1:0];
  assign too_deep     = (lvl_q == LVL_W'(IND_LIMIT)) && irq_pending;
  assign slot         = fidx_q[SLOT_W-1:0];
  assign pc_out       = pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      pat_q        <= '0;
      a_q          <= '0;
      b_q          <= '0;
      pc_q         <= '0;
      ma_q         <= '0;
      fidx_q       <= '0;
      wcnt_q       <= '0;
      lvl_q        <= '0;
      issue_q      <= 1'b0;
      issue_addr_q <= '0;
      op_wr_en     <= 1'b0;
      op_wr_slot   <= '0;
      op_wr_word   <= '0;
      op_wr_data   <= '0;
      done         <= 1'b0;
      abort        <= 1'b0;
    end else begin
      issue_q  <= 1'b0;
      op_wr_en <= 1'b0;
      done     <= 1'b0;
      abort    <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            pat_q   <= pattern;
            a_q     <= reg_a;
            b_q     <= reg_b;
            pc_q    <= pc_in;
            fidx_q  <= '0;
            state_q <= S_DISP;
          end
        end
        S_DISP: begin
          wcnt_q <= '0;
          lvl_q  <= '0;
          if (fields_spent || dec.ends) begin
            done    <= 1'b1;
            state_q <= S_IDLE;
          end else if (dec.from_regs) begin
            state_q <= S_REG;
          end else if (dec.gives_pc) begin
            op_wr_en   <= 1'b1;
            op_wr_slot <= slot;
            op_wr_word <= '0;
            op_wr_data <= DATA_W'(pc_q);
            state_q    <= S_NEXT;
          end else begin
            issue_q      <= 1'b1;
            issue_addr_q <= pc_q;
            state_q      <= S_WINL;
          end
        end
        S_REG: begin
          op_wr_en   <= 1'b1;
          op_wr_slot <= slot;
          op_wr_word <= wcnt_q;
          op_wr_data <= (wcnt_q == '0) ? a_q : b_q;
          if (last_word) state_q <= S_NEXT;
          else           wcnt_q  <= wcnt_q + WORD_W'(1);
        end
        S_WINL, S_WPTR: begin
          if (mem_rsp_valid) begin
            if (state_q == S_WINL && dec.reads_inline_value) begin
              op_wr_en   <= 1'b1;
              op_wr_slot <= slot;
              op_wr_word <= '0;
              op_wr_data <= mem_rsp_data;
              state_q    <= S_NEXT;
            end else if (rsp_ind) begin
              if (too_deep) begin
                abort   <= 1'b1;
                state_q <= S_IDLE;
              end else begin
                lvl_q        <= lvl_q + LVL_W'(1);
                issue_q      <= 1'b1;
                issue_addr_q <= rsp_addr;
                state_q      <= S_WPTR;
              end
            end else if (dec.gives_addr) begin
              op_wr_en   <= 1'b1;
              op_wr_slot <= slot;
              op_wr_word <= '0;
              op_wr_data <= DATA_W'(rsp_addr);
              state_q    <= S_NEXT;
            end else begin
              ma_q         <= rsp_addr;
              issue_q      <= 1'b1;
              issue_addr_q <= rsp_addr;
              state_q      <= S_WDAT;
            end
          end
        end
        S_WDAT: begin
          if (mem_rsp_valid) begin
            op_wr_en   <= 1'b1;
            op_wr_slot <= slot;
            op_wr_word <= wcnt_q;
            op_wr_data <= mem_rsp_data;
            if (last_word) begin
              state_q <= S_NEXT;
            end else begin
              wcnt_q       <= wcnt_q + WORD_W'(1);
              ma_q         <= ma_q + ADDR_W'(1);
              issue_q      <= 1'b1;
              issue_addr_q <= ma_q + ADDR_W'(1);
            end
          end
        end
        S_NEXT: begin
          pat_q  <= pat_q >> CODE_W;
          fidx_q <= fidx_q + FIDX_W'(1);
          if (dec.is_inline) pc_q <= pc_q + ADDR_W'(1);
          state_q <= S_DISP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8
  end_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && abort));

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) != S_IDLE && !$stable(pc_q)) |-> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R8
  abort_irq_chk: assert property (@(posedge clk) disable iff (rst)
    abort |-> $past(irq_pending));

  // R3
  end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done || abort) |-> (!mem_req_valid && !op_wr_en));

endmodule

// File: tb/operand_fetch_seq_tb.sv
module operand_fetch_seq_tb;

  localparam int DW = 16;
  localparam int AW = 15;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   pattern = '0;
  logic [DW-1:0] reg_a = '0, reg_b = '0;
  logic [AW-1:0] pc_in = '0;
  logic          irq_pending = 1'b0;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_req_ready = 1'b0;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          op_wr_en;
  logic [1:0]    op_wr_slot;
  logic [2:0]    op_wr_word;
  logic [DW-1:0] op_wr_data;
  logic [AW-1:0] pc_out;
  logic          done, abort;

  always #5 clk = ~clk;

  operand_fetch_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .pattern(pattern),
    .reg_a(reg_a), .reg_b(reg_b), .pc_in(pc_in), .irq_pending(irq_pending),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .op_wr_en(op_wr_en), .op_wr_slot(op_wr_slot),
    .op_wr_word(op_wr_word), .op_wr_data(op_wr_data), .pc_out(pc_out),
    .done(done), .abort(abort)
  );

  int          n_checks = 0;
  int          n_fail = 0;
  string       tag = "R1";
  logic [15:0] mem [256];
  int          exp_req[$];
  logic [20:0] exp_wr[$];
  logic [AW-1:0] exp_pc;
  bit          exp_abort;
  bit          fin_seen;
  bit          run_active = 0;
  int          ready_pct = 70;
  bit          pend = 0;
  int          pend_cnt = 0;
  logic [AW-1:0] pend_addr;
  bit          prev_stall = 0;
  logic [AW-1:0] prev_addr;

  task automatic chk(bit ok, string t, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic push_wr(int f, int k, logic [15:0] d);
    exp_wr.push_back({2'(f), 3'(k), d});
  endtask

  // behavioural reference: expected reads, writes, final pc and ending
  task automatic build_expect(logic [15:0] pat, logic [15:0] a, logic [15:0] b,
                              logic [14:0] pc0, bit irq);
    logic [15:0] p;
    logic [14:0] pcv, ma;
    logic [15:0] w;
    int code, lvl, n;
    p = pat; pcv = pc0;
    exp_req.delete(); exp_wr.delete(); exp_abort = 0;
    for (int f = 0; f < NF; f++) begin
      code = int'(p[3:0]);
      if (code == 0 || code > 12) break;
      if (code == 1) push_wr(f, 0, a);
      else if (code == 2 || code == 3) begin push_wr(f, 0, a); push_wr(f, 1, b); end
      else if (code == 4) begin exp_req.push_back(int'(pcv)); push_wr(f, 0, mem[pcv[7:0]]); end
      else if (code == 5) push_wr(f, 0, {1'b0, pcv});
      else begin
        exp_req.push_back(int'(pcv));
        w = mem[pcv[7:0]];
        lvl = 0;
        while (w[15]) begin
          if (lvl == 3 && irq) begin exp_abort = 1; exp_pc = pcv; return; end
          lvl++;
          exp_req.push_back(int'(w[14:0]));
          w = mem[w[7:0]];
        end
        ma = w[14:0];
        if (code == 6) push_wr(f, 0, {1'b0, ma});
        else begin
          n = (code == 7) ? 1 : (code <= 9) ? 2 : code - 7;
          for (int k = 0; k < n; k++) begin
            exp_req.push_back(int'(ma));
            push_wr(f, k, mem[ma[7:0]]);
            ma = ma + 15'd1;
          end
        end
      end
      if (code >= 4) pcv = pcv + 15'd1;
      p = p >> 4;
    end
    exp_pc = pcv;
  endtask

  // memory responder and per-clock comparison against the reference
  always @(negedge clk) begin
    bit rdy;
    if (rst) begin
      mem_req_ready = 0; mem_rsp_valid = 0; pend = 0; prev_stall = 0;
    end else begin
      if (mem_rsp_valid) mem_rsp_valid = 0;
      if (pend) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = mem[pend_addr[7:0]]; pend = 0;
        end
      end
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R9", "stalled request held",
            longint'(mem_req_addr), longint'(prev_addr));
      rdy = (($urandom % 100) < ready_pct);
      mem_req_ready = rdy;
      if (mem_req_valid && rdy) begin
        chk(!pend && !mem_rsp_valid, "R9", "single outstanding", longint'(pend), 0);
        if (exp_req.size() == 0) chk(0, tag, "unexpected read", longint'(mem_req_addr), -1);
        else begin
          int e;
          e = exp_req.pop_front();
          chk(int'(mem_req_addr) == e, tag, "read address", longint'(mem_req_addr), longint'(e));
        end
        pend = 1; pend_addr = mem_req_addr; pend_cnt = 1 + ($urandom % 3);
      end
      prev_stall = mem_req_valid && !rdy;
      prev_addr = mem_req_addr;
      if (op_wr_en) begin
        if (exp_wr.size() == 0)
          chk(0, tag, "unexpected write", longint'({op_wr_slot, op_wr_word, op_wr_data}), -1);
        else begin
          logic [20:0] e;
          e = exp_wr.pop_front();
          chk({op_wr_slot, op_wr_word, op_wr_data} == e, tag, "slot/word/data",
              longint'({op_wr_slot, op_wr_word, op_wr_data}), longint'(e));
        end
      end
      if (done || abort) begin
        if (!run_active) chk(0, tag, "ending with no walk", longint'({done, abort}), 0);
        else begin
          chk(abort == exp_abort && done == !exp_abort, tag, "done/abort",
              longint'({done, abort}), longint'({!exp_abort, exp_abort}));
          chk(pc_out == exp_pc, tag, "pc_out", longint'(pc_out), longint'(exp_pc));
          chk(exp_req.size() == 0 && exp_wr.size() == 0, tag, "missing reads/writes",
              longint'(exp_req.size() + exp_wr.size()), 0);
        end
        fin_seen = 1;
        run_active = 0;
      end
    end
  end

  task automatic run_case(string t, logic [15:0] pat, logic [15:0] a, logic [15:0] b,
                          logic [14:0] pc0, bit irq, bit poke);
    @(negedge clk);
    tag = t;
    build_expect(pat, a, b, pc0, irq);
    pattern = pat; reg_a = a; reg_b = b; pc_in = pc0; irq_pending = irq;
    fin_seen = 0; run_active = 1; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R10: a second start while busy must change nothing
      repeat (3) @(negedge clk);
      pattern = 16'h0001; reg_a = 16'hFFFF; pc_in = 15'h0000; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!fin_seen) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !abort && !op_wr_en && !mem_req_valid, "R1", "outputs in reset",
        longint'({done, abort, op_wr_en, mem_req_valid}), 0);
    chk(pc_out == 0, "R1", "pc_out in reset", longint'(pc_out), 0);
    rst = 0;
    @(negedge clk);
    chk(!done && !abort && !op_wr_en && !mem_req_valid && pc_out == 0, "R1",
        "first cycle after reset", longint'({done, abort, op_wr_en, mem_req_valid}), 0);

    // R3 null code at once
    run_case("R3", 16'h0000, 16'h1, 16'h2, 15'h0123, 0, 0);
    // R3 reserved code after one register operand
    run_case("R3", 16'h00E1, 16'h5555, 16'h6666, 15'h0010, 0, 0);
    // R4 register kinds, no memory
    run_case("R4", 16'h0321, 16'h1234, 16'hABCD, 15'h0100, 0, 0);
    // R2 four fields exhausted without a null code
    run_case("R2", 16'h2131, 16'h0F0F, 16'hF0F0, 15'h0200, 0, 0);

    // R5 inline constant and inline variable
    mem[8'h10] = 16'h5A5A;
    run_case("R5", 16'h0054, 16'h0, 16'h0, 15'h0010, 0, 0);
    // R5 program counter wrap
    mem[8'hFF] = 16'h1357; mem[8'h00] = 16'h2468;
    run_case("R5", 16'h0044, 16'h0, 16'h0, 15'h7FFF, 0, 0);

    // R6 direct address and one-word constant
    clear_mem();
    mem[8'h20] = 16'h0040; mem[8'h21] = 16'h0050; mem[8'h50] = 16'h7777;
    run_case("R6", 16'h0076, 16'h0, 16'h0, 15'h0020, 0, 0);
    // R6 R7 double integer through two indirect levels
    mem[8'h30] = 16'h8060; mem[8'h60] = 16'h8070; mem[8'h70] = 16'h0080;
    mem[8'h80] = 16'h1111; mem[8'h81] = 16'h2222;
    run_case("R7", 16'h0008, 16'h0, 16'h0, 15'h0030, 1, 0);
    // R7 five words across the address wrap, then three words
    mem[8'h38] = 16'h7FFE; mem[8'h39] = 16'h0090;
    mem[8'hFE] = 16'hA001; mem[8'hFF] = 16'hA002; mem[8'h00] = 16'hA003;
    mem[8'h01] = 16'hA004; mem[8'h02] = 16'hA005;
    mem[8'h90] = 16'hB001; mem[8'h91] = 16'hB002; mem[8'h92] = 16'hB003;
    run_case("R7", 16'h00AC, 16'h0, 16'h0, 15'h0038, 0, 0);
    // R2 R7 all four slots mixed
    mem[8'hA0] = 16'h00B0; mem[8'hB0] = 16'hC0DE; mem[8'hA1] = 16'h4321;
    mem[8'hA2] = 16'h00C0; mem[8'hA3] = 16'h00D0;
    for (int i = 0; i < 5; i++) mem[8'hC0 + i] = 16'h0C00 + 16'(i);
    mem[8'hD0] = 16'hD00D; mem[8'hD1] = 16'hD11D;
    run_case("R2", 16'h9C47, 16'h0, 16'h0, 15'h00A0, 0, 0);

    // R8 four indirect words with interrupt pending: abort
    clear_mem();
    mem[8'h40] = 16'h80E0; mem[8'hE0] = 16'h80E1; mem[8'hE1] = 16'h80E2;
    mem[8'hE2] = 16'h80E3; mem[8'hE3] = 16'h00F0; mem[8'hF0] = 16'h4242;
    run_case("R8", 16'h0071, 16'h9999, 16'h0, 15'h0040, 1, 0);
    // R8 same chain without interrupt: followed to the end
    run_case("R8", 16'h0071, 16'h9999, 16'h0, 15'h0040, 0, 0);
    // R8 three indirect words with interrupt pending: completes
    mem[8'hE2] = 16'h00F0;
    run_case("R8", 16'h0071, 16'h9999, 16'h0, 15'h0040, 1, 0);

    // R10 start while busy, under heavy stalls
    ready_pct = 30;
    run_case("R10", 16'h00AC, 16'h0, 16'h0, 15'h0038, 0, 1);

    // R9 random patterns with random stalls and latencies
    for (int it = 0; it < 24; it++) begin
      logic [15:0] pat;
      for (int i = 0; i < 256; i++) mem[i] = 16'($urandom) & 16'h7FFF;
      pat = '0;
      for (int f = 0; f < NF; f++) pat[f*4 +: 4] = 4'(1 + ($urandom % 12));
      if (($urandom % 4) == 0) pat[12 +: 4] = 4'd0;
      ready_pct = 20 + int'($urandom % 80);
      run_case("R9", pat, 16'($urandom), 16'($urandom), 15'($urandom), bit'($urandom % 2), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule